// File: doc/BRIEF.md
# Timer Capture/Compare Status Flags

This block keeps the event flags of a timer with several capture/compare channels. Each channel is either an output channel, which compares the counter value from outside the block against a compare value held in its channel register, or an input channel, which copies the counter value into that register when a capture strobe arrives. A compare match or a capture sets the channel's event flag. A capture that arrives while the event flag is still set also sets a sticky over-capture flag. When the counter runs center-aligned, a match counts only while the counter is counting up.

Software uses a simple register bus. Address 0 is the status word. Writing a 1 to a bit of the status word clears that flag, and writing a 0 leaves the bit as it is. Address k+1 is the register of channel k. A write to it loads the compare value. A read returns the register, and in input mode the read also clears that channel's event flag. Read data is combinational and is valid in the cycle of the read. The counter, prescaler, input filters and interrupt routing are outside this block. The flag vectors are also brought out as outputs so that interrupt routing can use them.

Top module: `ccflag_unit`

## Requirements
- R1: In output mode, when the counter is in edge-aligned mode (either direction) and equals the channel register, the channel's event flag is 1 after the next clock edge.
- R2: In center-aligned mode, an output channel's match sets its event flag only while counting up. A match while counting down leaves the flag unchanged.
- R3: In input mode, a capture strobe copies the counter into the channel register and sets the event flag at the next edge. A capture strobe on an output channel has no effect on its register or flags.
- R4: In input mode, the event flag is cleared by writing 1 to its status bit or by a bus read of the channel register at address k+1.
- R5: In output mode, the event flag is cleared only by writing 1 to its status bit. A read of the channel register or a write of 0 leaves it set.
- R6: A capture strobe on an input channel whose event flag holds 1 before the edge sets that channel's over-capture flag.
- R7: An over-capture flag is set only by R6 and is cleared only by writing 1 to its status bit. Reads leave it set.
- R8: When a hardware set and a software clear reach the same flag in one cycle, the flag ends up 1.
- R9: Status word at address 0: bit k is the event flag of channel k, bit NCH+k is the over-capture flag of channel k, and the bits above are 0. The flags also appear on cc_flag_o and ovc_flag_o with bit k for channel k.
- R10: While reset is asserted, and after it is released, all flags and all channel registers are 0.
- R11: A bus write to address k+1 loads channel k's register. A capture in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_i | input | CNT_W | Counter value |
| center_i | input | 1 | 1 = counter is in center-aligned mode |
| cnt_up_i | input | 1 | 1 = counter is counting up |
| dir_in_i | input | NCH | Per-channel mode: 1 = capture input, 0 = compare output |
| cap_i | input | NCH | Per-channel capture strobe, one cycle per event |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | 0 = status word, k+1 = channel k register |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data, combinational, 0 when no read is selected |
| cc_flag_o | output | NCH | Event flags, bit k for channel k |
| ovc_flag_o | output | NCH | Over-capture flags, bit k for channel k |

## Verification
The assertions check on every cycle, for each channel, that a qualifying match or capture sets the event flag, that a counting-down center-aligned match does not, that a capture latches the counter, that a capture on a set flag raises over-capture, and that flags stay set unless the matching status bit is written with 1. Only the bench's scenarios can show the bus view: the position of each bit in the status word, clear-on-read working only for input channels, a write of 0 having no effect, capture winning over a register write, and the reset values read back through the bus.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;

  // Per-channel controls decoded from the register bus
  typedef struct packed {
    logic clr_cc;   // write-one-to-clear of the event flag
    logic clr_ov;   // write-one-to-clear of the over-capture flag
    logic rd_reg;   // bus read of the channel register
    logic wr_reg;   // bus write of the channel register
  } chan_ctl_t;

endpackage

// File: rtl/ccflag_rstsync.sv
module ccflag_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ccflag_chan.sv
module ccflag_chan
  import ccflag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             center_i,
  input  logic             up_i,
  input  logic             is_in_i,
  input  logic             cap_i,
  input  chan_ctl_t        ctl_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic             cc_o,
  output logic             ov_o
);

  logic [CNT_W-1:0] ccr_q, ccr_d;
  logic             ccr_en;
  logic             cc_q, cc_d;
  logic             ov_q, ov_d;
  logic             dir_ok, match_hit, cap_hit, cc_clr;

  always_comb begin
    // center-aligned counting qualifies a match only on the way up
    dir_ok    = !center_i || up_i;
    match_hit = !is_in_i && dir_ok && (cnt_i == ccr_q);
    cap_hit   = is_in_i && cap_i;
    cc_clr    = ctl_i.clr_cc || (is_in_i && ctl_i.rd_reg);

    ccr_en = cap_hit || ctl_i.wr_reg;
    ccr_d  = cap_hit ? cnt_i : wdata_i;

    // a hardware set takes priority over any clear
    if (match_hit || cap_hit) begin
      cc_d = 1'b1;
    end else if (cc_clr) begin
      cc_d = 1'b0;
    end else begin
      cc_d = cc_q;
    end

    if (cap_hit && cc_q) begin
      ov_d = 1'b1;
    end else if (ctl_i.clr_ov) begin
      ov_d = 1'b0;
    end else begin
      ov_d = ov_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= '0;
      cc_q  <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      if (ccr_en) begin
        ccr_q <= ccr_d;
      end
      cc_q <= cc_d;
      ov_q <= ov_d;
    end
  end

  assign ccr_o = ccr_q;
  assign cc_o  = cc_q;
  assign ov_o  = ov_q;

endmodule

// File: rtl/ccflag_regif.sv
module ccflag_regif
  import ccflag_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [CNT_W-1:0]     bus_wdata_i,
  input  logic [NCH-1:0]       cc_i,
  input  logic [NCH-1:0]       ov_i,
  input  logic [NCH*CNT_W-1:0] ccr_i,
  output chan_ctl_t [NCH-1:0]  ctl_o,
  output logic [CNT_W-1:0]     rdata_o
);

  localparam int STAT_W = 2 * NCH;

  logic stat_wr, rd_sel, wr_sel;

  always_comb begin
    rd_sel  = bus_sel_i && !bus_wr_i;
    wr_sel  = bus_sel_i && bus_wr_i;
    stat_wr = wr_sel && (bus_addr_i == ADDR_W'(0));
    ctl_o   = '0;
    for (int k = 0; k < NCH; k++) begin
      ctl_o[k].clr_cc = stat_wr && bus_wdata_i[k];
      ctl_o[k].clr_ov = stat_wr && bus_wdata_i[NCH+k];
      ctl_o[k].rd_reg = rd_sel && (bus_addr_i == ADDR_W'(k + 1));
      ctl_o[k].wr_reg = wr_sel && (bus_addr_i == ADDR_W'(k + 1));
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_sel) begin
      if (bus_addr_i == ADDR_W'(0)) begin
        rdata_o[STAT_W-1:0] = {ov_i, cc_i};
      end
      for (int k = 0; k < NCH; k++) begin
        if (bus_addr_i == ADDR_W'(k + 1)) begin
          rdata_o = ccr_i[k*CNT_W +: CNT_W];
        end
      end
    end
  end

endmodule

// File: rtl/ccflag_unit.sv
module ccflag_unit
  import ccflag_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  localparam int ADDR_W = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              center_i,
  input  logic              cnt_up_i,
  input  logic [NCH-1:0]    dir_in_i,
  input  logic [NCH-1:0]    cap_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic [NCH-1:0]    cc_flag_o,
  output logic [NCH-1:0]    ovc_flag_o
);

  logic                 rst_sync_n;
  chan_ctl_t [NCH-1:0]  ctl;
  logic [NCH*CNT_W-1:0] ccr_flat;

  ccflag_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ccflag_regif #(
    .NCH    (NCH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_regif (
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .cc_i        (cc_flag_o),
    .ov_i        (ovc_flag_o),
    .ccr_i       (ccr_flat),
    .ctl_o       (ctl),
    .rdata_o     (bus_rdata_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    ccflag_chan #(
      .CNT_W (CNT_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cnt_i    (cnt_i),
      .center_i (center_i),
      .up_i     (cnt_up_i),
      .is_in_i  (dir_in_i[g]),
      .cap_i    (cap_i[g]),
      .ctl_i    (ctl[g]),
      .wdata_i  (bus_wdata_i),
      .ccr_o    (ccr_flat[g*CNT_W +: CNT_W]),
      .cc_o     (cc_flag_o[g]),
      .ov_o     (ovc_flag_o[g])
    );
  end

endmodule

// File: rtl/ccflag_unit_chk.sv
module ccflag_unit_chk #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CNT_W-1:0]     cnt,
  input logic                 center,
  input logic                 up,
  input logic [NCH-1:0]       is_in,
  input logic [NCH-1:0]       cap,
  input logic                 sel,
  input logic                 wr,
  input logic [ADDR_W-1:0]    addr,
  input logic [CNT_W-1:0]     wdata,
  input logic [NCH-1:0]       cc,
  input logic [NCH-1:0]       ov,
  input logic [NCH*CNT_W-1:0] ccr
);

  logic stat_wr;
  assign stat_wr = sel && wr && (addr == ADDR_W'(0));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R1
    a_r1_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_in[i] && !center && cnt == ccr[i*CNT_W +: CNT_W]) |=> cc[i]);

    // R2
    a_r2_center_down_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!cc[i] && !is_in[i] && center && !up) |=> !cc[i]);

    // R3, R8: capture sets the flag even against a same-cycle clear
    a_r3_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (is_in[i] && cap[i]) |=> (cc[i] && ccr[i*CNT_W +: CNT_W] == $past(cnt)));

    // R5
    a_r5_match_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cc[i] && !is_in[i] && !(stat_wr && wdata[i])) |=> cc[i]);

    // R6
    a_r6_overcapture: assert property (@(posedge clk) disable iff (!rst_n)
      (is_in[i] && cap[i] && cc[i]) |=> ov[i]);

    // R7
    a_r7_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ov[i] && !(stat_wr && wdata[NCH+i])) |=> ov[i]);

    // R7
    a_r7_ov_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!ov[i] && !(is_in[i] && cap[i])) |=> !ov[i]);
  end

endmodule

bind ccflag_unit ccflag_unit_chk #(
  .NCH    (NCH),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .cnt    (cnt_i),
  .center (center_i),
  .up     (cnt_up_i),
  .is_in  (dir_in_i),
  .cap    (cap_i),
  .sel    (bus_sel_i),
  .wr     (bus_wr_i),
  .addr   (bus_addr_i),
  .wdata  (bus_wdata_i),
  .cc     (cc_flag_o),
  .ov     (ovc_flag_o),
  .ccr    (ccr_flat)
);

// File: tb/ccflag_unit_tb_top.sv
module ccflag_unit_tb_top;

  // channels 0,1 compare outputs; channels 2,3 capture inputs
  localparam logic [3:0] DIR = 4'b1100;

  typedef struct packed {
    logic [3:0]  cap;
    logic        ctr;
    logic        up;
    logic [15:0] cnt;
    logic        sel;
    logic        wr;
    logic [2:0]  addr;
    logic [15:0] wd;
    logic        chk;
    logic [15:0] exp;
    logic [7:0]  req;
  } row_t;

  localparam int NROW = 38;
  // each row is one cycle; chk compares read data before that cycle's edge
  localparam row_t TBL [NROW] = '{
    '{4'h0,1'b0,1'b0,16'hFFFF,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0000,8'd10}, // R10 status
    '{4'h0,1'b0,1'b0,16'hFFFF,1'b1,1'b0,3'd1,16'h0000,1'b1,16'h0000,8'd10}, // R10 register
    '{4'h0,1'b0,1'b0,16'hFFFF,1'b1,1'b1,3'd1,16'h0010,1'b0,16'h0000,8'd11}, // R11 ch0 cmp
    '{4'h0,1'b0,1'b0,16'hFFFF,1'b1,1'b1,3'd2,16'h0020,1'b0,16'h0000,8'd11}, // R11 ch1 cmp
    '{4'h0,1'b0,1'b1,16'h0010,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0000,8'd1},  // R1 match now
    '{4'h0,1'b0,1'b1,16'h0011,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0001,8'd1},  // R1 flag seen
    '{4'h0,1'b0,1'b1,16'h0011,1'b1,1'b0,3'd1,16'h0000,1'b1,16'h0010,8'd11}, // R11 readback
    '{4'h0,1'b0,1'b1,16'h0011,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0001,8'd5},  // R5 read no clr
    '{4'h0,1'b0,1'b1,16'h0011,1'b1,1'b1,3'd0,16'h0000,1'b0,16'h0000,8'd5},  // write 0
    '{4'h0,1'b0,1'b1,16'h0011,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0001,8'd5},  // R5 still set
    '{4'h0,1'b0,1'b1,16'h0011,1'b1,1'b1,3'd0,16'h0001,1'b0,16'h0000,8'd5},  // w1c
    '{4'h0,1'b0,1'b1,16'h0011,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0000,8'd5},  // R5 cleared
    '{4'h0,1'b1,1'b0,16'h0020,1'b0,1'b0,3'd0,16'h0000,1'b0,16'h0000,8'd2},  // down match
    '{4'h0,1'b1,1'b0,16'h0021,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0000,8'd2},  // R2 suppressed
    '{4'h0,1'b1,1'b1,16'h0020,1'b0,1'b0,3'd0,16'h0000,1'b0,16'h0000,8'd2},  // up match
    '{4'h0,1'b1,1'b1,16'h0021,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0002,8'd2},  // R2 set
    '{4'h0,1'b0,1'b1,16'h0021,1'b1,1'b1,3'd0,16'h0002,1'b0,16'h0000,8'd2},
    '{4'h4,1'b0,1'b1,16'h0123,1'b0,1'b0,3'd0,16'h0000,1'b0,16'h0000,8'd3},  // cap ch2
    '{4'h0,1'b0,1'b1,16'h0124,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0004,8'd3},  // R3 flag
    '{4'h1,1'b0,1'b1,16'h0200,1'b1,1'b0,3'd3,16'h0000,1'b1,16'h0123,8'd3},  // R3 value; ch0 strobe
    '{4'h0,1'b0,1'b1,16'h0201,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0000,8'd4},  // R4 read-clear
    '{4'h0,1'b0,1'b1,16'h0201,1'b1,1'b0,3'd1,16'h0000,1'b1,16'h0010,8'd3},  // R3 ch0 ignored
    '{4'h8,1'b0,1'b1,16'h0300,1'b0,1'b0,3'd0,16'h0000,1'b0,16'h0000,8'd6},
    '{4'h8,1'b0,1'b1,16'h0301,1'b0,1'b0,3'd0,16'h0000,1'b0,16'h0000,8'd6},
    '{4'h0,1'b0,1'b1,16'h0302,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0088,8'd6},  // R6 ov3 bit7
    '{4'h0,1'b0,1'b1,16'h0302,1'b1,1'b0,3'd4,16'h0000,1'b1,16'h0301,8'd3},  // R3 newest
    '{4'h0,1'b0,1'b1,16'h0302,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0080,8'd7},  // R7 read keeps ov
    '{4'h0,1'b0,1'b1,16'h0302,1'b1,1'b1,3'd0,16'h0080,1'b0,16'h0000,8'd7},
    '{4'h0,1'b0,1'b1,16'h0302,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0000,8'd7},  // R7 w1c
    '{4'h4,1'b0,1'b1,16'h0400,1'b0,1'b0,3'd0,16'h0000,1'b0,16'h0000,8'd8},
    '{4'h4,1'b0,1'b1,16'h0401,1'b1,1'b1,3'd0,16'h0004,1'b0,16'h0000,8'd8},  // set+clear
    '{4'h0,1'b0,1'b1,16'h0402,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0044,8'd8},  // R8 set wins
    '{4'h0,1'b0,1'b1,16'h0402,1'b1,1'b1,3'd0,16'h00FF,1'b0,16'h0000,8'd8},
    '{4'h0,1'b0,1'b1,16'h0402,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0000,8'd8},
    '{4'h8,1'b0,1'b1,16'h0555,1'b1,1'b1,3'd4,16'h0AAA,1'b0,16'h0000,8'd11}, // cap vs write
    '{4'h0,1'b0,1'b1,16'h0556,1'b1,1'b0,3'd4,16'h0000,1'b1,16'h0555,8'd11}, // R11 cap wins
    '{4'h0,1'b0,1'b1,16'h0556,1'b1,1'b1,3'd0,16'h00FF,1'b0,16'h0000,8'd9},
    '{4'h0,1'b0,1'b1,16'h0556,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0000,8'd9}   // R9 upper zero
  };

  logic        clk;
  logic        rst_n;
  logic [15:0] cnt;
  logic        center, up;
  logic [3:0]  dir_in, cap;
  logic        sel, wr;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  cc_flag, ovc_flag;

  int n_chk;
  int n_fail;

  ccflag_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_i       (cnt),
    .center_i    (center),
    .cnt_up_i    (up),
    .dir_in_i    (dir_in),
    .cap_i       (cap),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .cc_flag_o   (cc_flag),
    .ovc_flag_o  (ovc_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic ct, input logic u,
                       input logic [15:0] cv, input logic s, input logic w,
                       input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cap = c; center = ct; up = u; cnt = cv;
    sel = s; wr = w; addr = a; wdata = d;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; dir_in = DIR;
    cap = '0; center = 1'b0; up = 1'b0; cnt = 16'hFFFF;
    sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int r = 0; r < NROW; r++) begin
      drive(TBL[r].cap, TBL[r].ctr, TBL[r].up, TBL[r].cnt,
            TBL[r].sel, TBL[r].wr, TBL[r].addr, TBL[r].wd);
      if (TBL[r].chk) check($sformatf("R%0d row %0d", TBL[r].req, r), rdata, TBL[r].exp);
    end

    // R1: edge-aligned match while counting down still sets (ch1 compare 0x20)
    drive(4'h0, 1'b0, 1'b0, 16'h0020, 1'b0, 1'b0, 3'd0, 16'h0);
    drive(4'h0, 1'b0, 1'b0, 16'h0021, 1'b0, 1'b0, 3'd0, 16'h0);
    check("R1 down-count edge mode", {12'h0, cc_flag}, 16'h0002);

    // R9: flag outputs mirror the status layout; over-capture on ch2
    drive(4'h4, 1'b0, 1'b1, 16'h0700, 1'b0, 1'b0, 3'd0, 16'h0);
    drive(4'h4, 1'b0, 1'b1, 16'h0701, 1'b0, 1'b0, 3'd0, 16'h0);
    drive(4'h0, 1'b0, 1'b1, 16'h0702, 1'b1, 1'b0, 3'd0, 16'h0);
    check("R9 status word", rdata, 16'h0046);
    check("R9 ovc_flag_o", {12'h0, ovc_flag}, 16'h0004);
    check("R9 cc_flag_o", {12'h0, cc_flag}, 16'h0006);

    // R5: reading an output channel register leaves its flag set
    drive(4'h0, 1'b0, 1'b1, 16'h0702, 1'b1, 1'b0, 3'd2, 16'h0);
    check("R5 ch1 register value", rdata, 16'h0020);
    drive(4'h0, 1'b0, 1'b1, 16'h0702, 1'b0, 1'b0, 3'd0, 16'h0);
    check("R5 ch1 flag after read", {12'h0, cc_flag}, 16'h0006);

    // R10: reset in the middle of activity
    @(negedge clk);
    sel = 1'b0;
    rst_n = 1'b0;
    #2;
    check("R10 flags in reset", {8'h0, ovc_flag, cc_flag}, 16'h0000);
    sel = 1'b1; wr = 1'b0; addr = 3'd3;
    #1;
    check("R10 ch2 register in reset", rdata, 16'h0000);
    @(negedge clk);
    sel = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R10 flags after release", {8'h0, ovc_flag, cc_flag}, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule